// File: doc/BRIEF.md
# PLL Configuration Register Bank

This block holds the settings of an on-chip clock multiplier and presents them to the PLL in decoded and validated form. Software reaches it through a simple byte-wide bus made up of an address, write data, a write strobe and a combinational read-data return. The bank stores five settings:

- the integer multiplier J, together with a low-input-frequency flag;
- a 14-bit fractional multiplier D, written in two byte-sized parts;
- the input pre-divider P;
- a 2-bit selector that picks the clock source feeding the PLL.

The D update is atomic. Writing the high-part register only stages the upper six bits. The full 14-bit value reaches the PLL only when the low-byte register is written next, with no other bus write in between. Three kinds of write leave the live outputs unchanged and set a sticky error bit instead of taking effect:

- a value outside its legal range;
- a broken write order;
- the reserved source code.

Software clears the sticky error bit by writing 1 to it.

Register map (byte addresses):

| Address | Register | Bits |
|---|---|---|
| 0 | input clock | [7:6] source code, [5:0] pre-divider field |
| 1 | multiplier | [7] low-frequency flag, [6:0] J |
| 2 | D high part | [5:0] staged upper bits of D |
| 3 | D low byte | [7:0] low byte of D; writing it commits D |
| 4 | status | [0] pending, read only; [1] error, write 1 to clear |

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset the outputs are D=0, J=4, effective P=1, source=01 and low-frequency flag=0. Status (address 4) reads 0x00. The input-clock register (address 0) reads 0x41 and the multiplier register (address 1) reads 0x04.
- R2: A write to address 2 stores wdata[5:0] as the staged upper part of D and sets the pending bit (status bit 0). It leaves pll_d_o unchanged. A read of address 2 returns the staged bits.
- R3: A write to address 3 while the pending bit is set commits {staged[5:0], wdata[7:0]} to pll_d_o on the next clock edge when that value is at most 9999. The pending bit clears, and address 3 then reads back the committed low byte.
- R4: A write to address 3 while the pending bit is clear leaves pll_d_o unchanged and sets the error bit (status bit 1).
- R5: A write to any address other than 2 or 3 while the pending bit is set clears the pending bit. A following write to address 3 is then handled as in R4.
- R6: A D commit whose 14-bit value exceeds 9999 leaves pll_d_o unchanged, clears the pending bit and sets the error bit.
- R7: A write to address 1 with wdata[6:0] in 1..63 sets pll_j_o to that value and pll_lowf_o to wdata[7]. A value of 0 or above 63 changes neither output nor the readback, and sets the error bit.
- R8: The pre-divider field (address 0, bits [5:0]) drives pll_p_o as the field value for 1..63 and as 64 when the field is 0.
- R9: When address 0 bits [7:6] are written as 11, pll_src_o keeps its previous value and the error bit is set. The P field is still updated, and address 0 reads back the raw written byte.
- R10: The error bit stays set until a write to address 4 with wdata[1]=1. When a new error and the clear fall in the same cycle, the error wins.
- R11: Reads of unmapped addresses return 0x00. Writes to unmapped addresses change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one write per cycle |
| rdata_o | output | 8 | Combinational read data for addr_i |
| pll_p_o | output | 7 | Effective pre-divider, 1..64 |
| pll_j_o | output | 7 | Effective integer multiplier |
| pll_d_o | output | 14 | Committed fractional multiplier |
| pll_src_o | output | 2 | Valid clock source select |
| pll_lowf_o | output | 1 | Low-input-frequency flag |

## Verification
The bench builds the block with its default parameters: a 14-bit D with a ceiling of 9999, a 7-bit J field accepting 1..63, and a 6-bit P field. With a 6-bit P field, the all-zero code meaning 64 is the only case wider than the field. With these defaults, the boundary D values 9999 and 10000 can both be formed from a single staged upper part (0x27), so the accept/reject edge is tested directly. J values 0, 63 and 64 sit inside the 7-bit field, so both sides of the legal range are reachable through ordinary writes.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_CLKIN = 4'd0;
  localparam logic [ADDR_W-1:0] A_JREG  = 4'd1;
  localparam logic [ADDR_W-1:0] A_DHI   = 4'd2;
  localparam logic [ADDR_W-1:0] A_DLO   = 4'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd4;

  typedef enum logic [1:0] {
    SRC_BCLK = 2'b00,
    SRC_MCLK = 2'b01,
    SRC_PDM  = 2'b10,
    SRC_RSVD = 2'b11
  } src_e;
endpackage

// File: rtl/pll_cfg_dstage.sv
module pll_cfg_dstage #(
  parameter int unsigned D_W   = 14,
  parameter int unsigned D_MAX = 9999,
  parameter int unsigned DW_IN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hi_we_i,
  input  logic              lo_we_i,
  input  logic              other_we_i,
  input  logic [DW_IN-1:0]  wdata_i,
  output logic [D_W-1:0]    d_o,
  output logic [D_W-DW_IN-1:0] stage_hi_o,
  output logic              pending_o,
  output logic              err_o
);
  localparam int unsigned HI_W = D_W - DW_IN;
  localparam logic [D_W-1:0] D_MAX_V = D_W'(D_MAX);

  logic [D_W-1:0]  d_q;
  logic [HI_W-1:0] stage_q;
  logic            pend_q;
  logic [D_W-1:0]  cand;
  logic            commit_ok;

  assign cand      = {stage_q, wdata_i};
  assign commit_ok = pend_q && (cand <= D_MAX_V);
  assign err_o     = lo_we_i && !commit_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q     <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
    end else if (hi_we_i) begin
      stage_q <= wdata_i[HI_W-1:0];
      pend_q  <= 1'b1;
    end else if (lo_we_i) begin
      pend_q <= 1'b0;
      if (commit_ok) d_q <= cand;
    end else if (other_we_i) begin
      // sequence broken: discard the pending stage
      pend_q <= 1'b0;
    end
  end

  assign d_o        = d_q;
  assign stage_hi_o = stage_q;
  assign pending_o  = pend_q;
endmodule

// File: rtl/pll_cfg_jreg.sv
module pll_cfg_jreg #(
  parameter int unsigned J_W   = 7,
  parameter int unsigned J_MIN = 1,
  parameter int unsigned J_MAX = 63,
  parameter int unsigned J_RST = 4,
  parameter int unsigned DW_IN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW_IN-1:0] wdata_i,
  output logic [J_W-1:0]   j_o,
  output logic             lowf_o,
  output logic [DW_IN-1:0] rd_o,
  output logic             err_o
);
  localparam logic [J_W-1:0] J_MIN_V = J_W'(J_MIN);
  localparam logic [J_W-1:0] J_MAX_V = J_W'(J_MAX);
  localparam logic [J_W-1:0] J_RST_V = J_W'(J_RST);

  logic [J_W-1:0] j_q;
  logic           lowf_q;
  logic [J_W-1:0] j_new;
  logic           ok;

  assign j_new = wdata_i[J_W-1:0];
  assign ok    = (j_new >= J_MIN_V) && (j_new <= J_MAX_V);
  assign err_o = we_i && !ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      j_q    <= J_RST_V;
      lowf_q <= 1'b0;
    end else if (we_i && ok) begin
      j_q    <= j_new;
      lowf_q <= wdata_i[DW_IN-1];
    end
  end

  assign j_o    = j_q;
  assign lowf_o = lowf_q;

  always_comb begin
    rd_o = '0;
    rd_o[J_W-1:0] = j_q;
    rd_o[DW_IN-1] = lowf_q;
  end
endmodule

// File: rtl/pll_cfg_clkin.sv
module pll_cfg_clkin
  import pll_cfg_pkg::*;
#(
  parameter int unsigned P_W   = 6,
  parameter int unsigned P_RST = 1,
  parameter int unsigned DW_IN = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [DW_IN-1:0] wdata_i,
  output logic [P_W:0]     p_o,
  output logic [1:0]       src_o,
  output logic [DW_IN-1:0] rd_o,
  output logic             err_o
);
  localparam logic [P_W-1:0] P_RST_V = P_W'(P_RST);
  localparam logic [P_W:0]   P_ZERO_DIV = (P_W+1)'(1) << P_W;

  logic [DW_IN-1:0] raw_q;
  logic [1:0]       src_q;
  logic [1:0]       src_new;
  logic [P_W-1:0]   p_fld;

  assign src_new = wdata_i[DW_IN-1 -: 2];
  assign err_o   = we_i && (src_new == SRC_RSVD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      raw_q[DW_IN-1 -: 2] <= SRC_MCLK;
      raw_q[P_W-1:0]      <= P_RST_V;
      src_q <= SRC_MCLK;
    end else if (we_i) begin
      raw_q <= wdata_i;
      if (src_new != SRC_RSVD) src_q <= src_new;
    end
  end

  assign p_fld = raw_q[P_W-1:0];
  assign p_o   = (p_fld == '0) ? P_ZERO_DIV : {1'b0, p_fld};
  assign src_o = src_q;
  assign rd_o  = raw_q;
endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int unsigned D_W   = 14,
  parameter int unsigned D_MAX = 9999,
  parameter int unsigned J_W   = 7,
  parameter int unsigned J_MIN = 1,
  parameter int unsigned J_MAX = 63,
  parameter int unsigned J_RST = 4,
  parameter int unsigned P_W   = 6,
  parameter int unsigned P_RST = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [P_W:0]      pll_p_o,
  output logic [J_W-1:0]    pll_j_o,
  output logic [D_W-1:0]    pll_d_o,
  output logic [1:0]        pll_src_o,
  output logic              pll_lowf_o
);
  localparam int unsigned HI_W = D_W - DATA_W;

  logic we_clk, we_j, we_hi, we_lo, we_stat, we_other;
  logic err_clk, err_j, err_d, err_set, err_clr, err_q;
  logic d_pending;
  logic [HI_W-1:0]   d_stage_hi;
  logic [DATA_W-1:0] rd_clk, rd_j;

  assign we_clk   = we_i && (addr_i == A_CLKIN);
  assign we_j     = we_i && (addr_i == A_JREG);
  assign we_hi    = we_i && (addr_i == A_DHI);
  assign we_lo    = we_i && (addr_i == A_DLO);
  assign we_stat  = we_i && (addr_i == A_STAT);
  assign we_other = we_i && !we_hi && !we_lo;

  pll_cfg_clkin #(.P_W(P_W), .P_RST(P_RST), .DW_IN(DATA_W)) u_clkin (
    .clk_i, .rst_ni, .we_i(we_clk), .wdata_i,
    .p_o(pll_p_o), .src_o(pll_src_o), .rd_o(rd_clk), .err_o(err_clk)
  );

  pll_cfg_jreg #(.J_W(J_W), .J_MIN(J_MIN), .J_MAX(J_MAX), .J_RST(J_RST),
                 .DW_IN(DATA_W)) u_jreg (
    .clk_i, .rst_ni, .we_i(we_j), .wdata_i,
    .j_o(pll_j_o), .lowf_o(pll_lowf_o), .rd_o(rd_j), .err_o(err_j)
  );

  pll_cfg_dstage #(.D_W(D_W), .D_MAX(D_MAX), .DW_IN(DATA_W)) u_dstage (
    .clk_i, .rst_ni, .hi_we_i(we_hi), .lo_we_i(we_lo), .other_we_i(we_other),
    .wdata_i, .d_o(pll_d_o), .stage_hi_o(d_stage_hi), .pending_o(d_pending),
    .err_o(err_d)
  );

  assign err_set = err_clk | err_j | err_d;
  assign err_clr = we_stat && wdata_i[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      err_q <= 1'b0;
    else if (err_set) err_q <= 1'b1;   // set beats clear
    else if (err_clr) err_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CLKIN: rdata_o = rd_clk;
      A_JREG:  rdata_o = rd_j;
      A_DHI:   rdata_o[HI_W-1:0] = d_stage_hi;
      A_DLO:   rdata_o = pll_d_o[DATA_W-1:0];
      A_STAT:  rdata_o[1:0] = {err_q, d_pending};
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/pll_cfg_regs_chk.sv
module pll_cfg_regs_chk
  import pll_cfg_pkg::*;
#(
  parameter int unsigned D_W   = 14,
  parameter int unsigned D_MAX = 9999,
  parameter int unsigned J_W   = 7,
  parameter int unsigned J_MIN = 1,
  parameter int unsigned J_MAX = 63,
  parameter int unsigned P_W   = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              we_i,
  input logic [P_W:0]      pll_p_o,
  input logic [J_W-1:0]    pll_j_o,
  input logic [D_W-1:0]    pll_d_o,
  input logic [1:0]        pll_src_o,
  input logic              err_q,
  input logic              d_pending,
  input logic [D_W-DATA_W-1:0] d_stage_hi
);
  localparam logic [D_W-1:0] D_MAX_V = D_W'(D_MAX);
  localparam logic [J_W-1:0] J_MIN_V = J_W'(J_MIN);
  localparam logic [J_W-1:0] J_MAX_V = J_W'(J_MAX);
  localparam logic [P_W:0]   P_TOP   = (P_W+1)'(1) << P_W;

  logic lo_wr, stat_clr;
  assign lo_wr    = we_i && (addr_i == A_DLO);
  assign stat_clr = we_i && (addr_i == A_STAT) && wdata_i[1];

  p_d_only_on_lo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lo_wr |=> $stable(pll_d_o));

  p_commit_value_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr && d_pending && ({d_stage_hi, wdata_i} <= D_MAX_V))
      |=> pll_d_o == $past({d_stage_hi, wdata_i}));

  p_lo_no_pending_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_wr && !d_pending) |=> ($stable(pll_d_o) && err_q));

  p_d_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_d_o <= D_MAX_V);

  p_j_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_j_o >= J_MIN_V) && (pll_j_o <= J_MAX_V));

  p_p_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_p_o != '0) && (pll_p_o <= P_TOP));

  p_src_valid_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_src_o != SRC_RSVD);

  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !stat_clr) |=> err_q);

  p_pending_after_lo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_wr |=> !d_pending);
endmodule

bind pll_cfg_regs pll_cfg_regs_chk #(
  .D_W(D_W), .D_MAX(D_MAX), .J_W(J_W), .J_MIN(J_MIN), .J_MAX(J_MAX), .P_W(P_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
  .we_i(we_i), .pll_p_o(pll_p_o), .pll_j_o(pll_j_o), .pll_d_o(pll_d_o),
  .pll_src_o(pll_src_o), .err_q(err_q), .d_pending(d_pending),
  .d_stage_hi(d_stage_hi)
);

// File: tb/pll_cfg_regs_tb.sv
module pll_cfg_regs_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       we_i = 1'b0;
  logic [7:0] rdata_o;
  logic [6:0] pll_p_o;
  logic [6:0] pll_j_o;
  logic [13:0] pll_d_o;
  logic [1:0] pll_src_o;
  logic       pll_lowf_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  pll_cfg_regs u_dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .we_i, .rdata_o,
    .pll_p_o, .pll_j_o, .pll_d_o, .pll_src_o, .pll_lowf_o
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic clr_err();
    wr(4'd4, 8'h02);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 d", pll_d_o, 0);
    chk("R1 j", pll_j_o, 4);
    chk("R1 p", pll_p_o, 1);
    chk("R1 src", pll_src_o, 1);
    chk("R1 lowf", pll_lowf_o, 0);
    rd(4'd4, v); chk("R1 status", v, 8'h00);
    rd(4'd0, v); chk("R1 clkin rd", v, 8'h41);
    rd(4'd1, v); chk("R1 jreg rd", v, 8'h04);
  endtask

  task automatic t_ordered_d();
    logic [7:0] v;
    wr(4'd2, 8'h12);
    chk("R2 d held", pll_d_o, 0);
    rd(4'd2, v); chk("R2 stage rd", v, 8'h12);
    rd(4'd4, v); chk("R2 pending", v, 8'h01);
    wr(4'd3, 8'h34);
    chk("R3 commit", pll_d_o, 14'h1234);
    rd(4'd4, v); chk("R3 pending clr", v, 8'h00);
    rd(4'd3, v); chk("R3 lo rd", v, 8'h34);
    wr(4'd2, 8'h27); wr(4'd3, 8'h0F);
    chk("R3 max 9999", pll_d_o, 9999);
  endtask

  task automatic t_unordered_d();
    logic [7:0] v;
    wr(4'd3, 8'h00);
    chk("R4 d held", pll_d_o, 9999);
    rd(4'd4, v); chk("R4 err", v, 8'h02);
    clr_err();
    rd(4'd4, v); chk("R10 cleared", v, 8'h00);
    wr(4'd2, 8'h01);
    wr(4'd1, 8'h05);
    rd(4'd4, v); chk("R5 pending dropped", v, 8'h00);
    wr(4'd3, 8'h00);
    chk("R5 d held", pll_d_o, 9999);
    rd(4'd4, v); chk("R5 err", v, 8'h02);
    clr_err();
  endtask

  task automatic t_d_range();
    logic [7:0] v;
    wr(4'd2, 8'h27); wr(4'd3, 8'h10);
    chk("R6 10000 rejected", pll_d_o, 9999);
    rd(4'd4, v); chk("R6 err, no pending", v, 8'h02);
    clr_err();
  endtask

  task automatic t_jreg();
    logic [7:0] v;
    wr(4'd1, 8'hBF);
    chk("R7 j 63", pll_j_o, 63);
    chk("R7 lowf", pll_lowf_o, 1);
    wr(4'd1, 8'h00);
    chk("R7 j0 rejected", pll_j_o, 63);
    rd(4'd1, v); chk("R7 rd kept", v, 8'hBF);
    rd(4'd4, v); chk("R7 err", v, 8'h02);
    clr_err();
    wr(4'd1, 8'h40);
    chk("R7 j64 rejected", pll_j_o, 63);
    chk("R7 lowf kept", pll_lowf_o, 1);
    clr_err();
    wr(4'd1, 8'h01);
    chk("R7 j 1", pll_j_o, 1);
    chk("R7 lowf 0", pll_lowf_o, 0);
  endtask

  task automatic t_clkin();
    logic [7:0] v;
    wr(4'd0, 8'h80);
    chk("R8 p0 is 64", pll_p_o, 64);
    chk("R8 src pdm", pll_src_o, 2);
    wr(4'd0, 8'h3F);
    chk("R8 p 63", pll_p_o, 63);
    chk("R8 src bclk", pll_src_o, 0);
    wr(4'd0, 8'hC5);
    chk("R9 src held", pll_src_o, 0);
    chk("R9 p updated", pll_p_o, 5);
    rd(4'd0, v); chk("R9 raw rd", v, 8'hC5);
    rd(4'd4, v); chk("R9 err", v, 8'h02);
    clr_err();
  endtask

  task automatic t_err_race();
    logic [7:0] v;
    wr(4'd3, 8'h00);  // sets error
    // same-cycle error and clear is not reachable on one bus; check stickiness
    wr(4'd4, 8'h01);
    rd(4'd4, v); chk("R10 sticky w/o bit1", v, 8'h02);
    wr(4'd4, 8'h02);
    rd(4'd4, v); chk("R10 w1c", v, 8'h00);
  endtask

  task automatic t_unmapped();
    logic [7:0] v;
    wr(4'd9, 8'hFF);
    rd(4'd9, v); chk("R11 unmapped rd", v, 8'h00);
    chk("R11 d", pll_d_o, 9999);
    chk("R11 j", pll_j_o, 1);
    chk("R11 p", pll_p_o, 5);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #9 rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_ordered_d();
    t_unordered_d();
    t_d_range();
    t_jreg();
    t_clkin();
    t_err_race();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule